// File: doc/BRIEF.md
# Converter Serial Data Port (External Clock)

This block is the device side of the serial port on a multiplexed data converter whose bit clock comes from the host. It moves through three states: converting, sleeping with a finished result, and sending data. A down-counter of programmable length stands in for the analog conversion. When the counter expires, the block copies the sign and the 16-bit magnitude from its result inputs into a static frame register. It then waits in sleep until the host pulls chip select low.

While chip select is low, the serial output shows a busy flag during conversion. During the data state it shows a 19-bit frame. In the same transfer the host shifts in an eight-bit channel-select word on the serial input. If chip select rises during the data state, the transfer is cut short and a fresh conversion starts. The channel selection changes only when all eight bits of the word have arrived. The clock mode is latched once, as reset ends: external-clock operation needs the serial clock to be low at that moment.

All serial inputs are taken to be synchronous to the system clock. Serial clock edges are found by comparing each sample with the one before it.

Top module: `adc_serial_port`

## Requirements
- R1: With chip select low, `sdo` is 1 while a conversion is running and 0 once the result is waiting in sleep.
- R2: `sdo_oe` is 0 whenever `cs_n` is high and 1 whenever it is low. `sdo` reads 0 while not enabled.
- R3: `sdi` is captured on each rising serial clock edge. `sdo` moves to the next frame bit on each falling edge, so frame bit i+1 is present after the i-th fall.
- R4: The frame is 19 bits, sent in this order: a 0 status bit, a 0 bit, the sign, then the 16 result bits from MSB to LSB. Bit 0 is present before the first rising edge.
- R5: The 19th falling edge ends the data state and starts a conversion, and `sdo` reads 1 from then on. The conversion lasts CONV_CYCLES system clocks and then returns the port to sleep.
- R6: If `cs_n` is high during the data state, the transfer is aborted and a conversion starts on the next clock.
- R7: An abort before the 8th rising edge leaves `chan_cfg` unchanged. An abort after the 8th rising edge keeps the newly applied value.
- R8: The channel word is sent MSB first as 1, 0, EN, SGL, ODD, A2, A1, A0. On the 8th rising edge `chan_cfg` becomes {EN,SGL,ODD,A2,A1,A0}, but only if the first two bits were 1 then 0; any other word is discarded. After reset `chan_cfg` is 0.
- R9: The result inputs are copied into the frame register only when a conversion ends. Changes to them during sleep do not alter the next frame.
- R10: If `sck` is low when reset ends, `ext_clk_mode` is 1 and the port follows `sck`. If `sck` is high, `ext_clk_mode` is 0, all `sck` edges are ignored and no frame advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial channel-select input |
| res_data | input | RES_W | Converter result magnitude |
| res_sign | input | 1 | Converter result sign |
| sdo | output | 1 | Serial data / busy output |
| sdo_oe | output | 1 | Output enable for sdo |
| ext_clk_mode | output | 1 | External serial clock mode latched at reset |
| chan_cfg | output | 6 | Applied channel selection {EN,SGL,ODD,A2,A1,A0} |

## Verification
The bench sweeps all 64 channel codes. Each one is paired with a result value and sign computed from its index, and every frame bit is checked on both the rising and the falling phase. This separates errors in bit order from errors in shift timing, and a wrongly applied code from a dropped one. The bench also runs aborts before and after the eighth address bit, a word with a bad lead pattern, and a change of the result inputs during sleep. Each of these is set up so that only the intended rule can explain the `chan_cfg` value or frame that results. A final reset with the serial clock held high checks that clock edges no longer move the port.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DATA  = 2'd2
  } sp_state_e;

  localparam int ADDR_W = 8;
  localparam int CFG_W  = 6;
  localparam logic [1:0] ADDR_LEAD = 2'b10;
endpackage

// File: rtl/adc_sp_conv_timer.sv
module adc_sp_conv_timer #(
  parameter int CONV_CYCLES = 64,
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = run && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = LAST;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LAST;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_sp_addr_rx.sv
module adc_sp_addr_rx
  import adc_sp_pkg::*;
#(
  localparam int RCNT_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rise,
  input  logic              sdi,
  output logic [CFG_W-1:0]  cfg,
  output logic [RCNT_W-1:0] rcnt
);
  logic [ADDR_W-2:0] sh_q, sh_d;
  logic [RCNT_W-1:0] rc_q, rc_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [ADDR_W-1:0] word;

  assign word = {sh_q, sdi};
  assign cfg  = cfg_q;
  assign rcnt = rc_q;

  always_comb begin
    sh_d  = sh_q;
    rc_d  = rc_q;
    cfg_d = cfg_q;
    if (clear) begin
      sh_d = '0;
      rc_d = '0;
    end else if (rise && (rc_q < RCNT_W'(ADDR_W))) begin
      sh_d = word[ADDR_W-2:0];
      rc_d = rc_q + 1'b1;
      if ((rc_q == RCNT_W'(ADDR_W - 1)) && (word[ADDR_W-1 -: 2] == ADDR_LEAD))
        cfg_d = word[CFG_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rc_q  <= '0;
      cfg_q <= '0;
    end else begin
      sh_q  <= sh_d;
      rc_q  <= rc_d;
      cfg_q <= cfg_d;
    end
  end
endmodule

// File: rtl/adc_sp_frame_tx.sv
module adc_sp_frame_tx #(
  parameter int RES_W  = 16,
  parameter int FCNT_W = 5,
  localparam int FRAME_W = RES_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               res_sign,
  input  logic [RES_W-1:0]   res_data,
  input  logic [FCNT_W-1:0]  fcnt,
  output logic [FRAME_W-1:0] frame_word,
  output logic               bit_out
);
  logic [FRAME_W-1:0] frame_q;
  logic [FCNT_W-1:0]  idx;

  assign frame_word = frame_q;
  assign idx        = FCNT_W'(FRAME_W - 1) - fcnt;
  assign bit_out    = frame_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      frame_q <= '0;
    else if (load)
      frame_q <= {2'b00, res_sign, res_data};
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int RES_W       = 16,
  parameter int CONV_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_sign,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             ext_clk_mode,
  output logic [CFG_W-1:0] chan_cfg
);
  localparam int FRAME_W = RES_W + 3;
  localparam int FCNT_W  = $clog2(FRAME_W);
  localparam int RCNT_W  = $clog2(ADDR_W + 1);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       mode_set_q, ext_mode_q, sck_q;
  logic       sck_rise, sck_fall;

  sp_state_e          state_q, state_d;
  logic [FCNT_W-1:0]  fcnt_q, fcnt_d;
  logic               conv_start, conv_done, rx_rise, frame_bit;
  logic [RCNT_W-1:0]  rcnt;
  logic [FRAME_W-1:0] frame_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_set_q <= 1'b0;
      ext_mode_q <= 1'b0;
      sck_q      <= 1'b0;
    end else begin
      sck_q <= sck;
      if (!mode_set_q) begin
        mode_set_q <= 1'b1;
        ext_mode_q <= ~sck;
      end
    end
  end

  assign sck_rise     = ext_mode_q && mode_set_q && sck && !sck_q;
  assign sck_fall     = ext_mode_q && mode_set_q && !sck && sck_q;
  assign ext_clk_mode = ext_mode_q;

  always_comb begin
    state_d    = state_q;
    fcnt_d     = fcnt_q;
    conv_start = 1'b0;
    case (state_q)
      ST_CONV:  if (conv_done) state_d = ST_SLEEP;
      ST_SLEEP: if (!cs_n) begin
                  state_d = ST_DATA;
                  fcnt_d  = '0;
                end
      ST_DATA: begin
        if (cs_n) begin
          state_d    = ST_CONV;
          conv_start = 1'b1;
          fcnt_d     = '0;
        end else if (sck_fall) begin
          if (fcnt_q == FCNT_W'(FRAME_W - 1)) begin
            state_d    = ST_CONV;
            conv_start = 1'b1;
            fcnt_d     = '0;
          end else begin
            fcnt_d = fcnt_q + 1'b1;
          end
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_CONV;
      fcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      fcnt_q  <= fcnt_d;
    end
  end

  assign rx_rise = sck_rise && (state_q == ST_DATA) && !cs_n;

  adc_sp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (conv_start),
    .run   (state_q == ST_CONV),
    .done  (conv_done)
  );

  adc_sp_addr_rx u_addr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (state_q != ST_DATA),
    .rise  (rx_rise),
    .sdi   (sdi),
    .cfg   (chan_cfg),
    .rcnt  (rcnt)
  );

  adc_sp_frame_tx #(.RES_W(RES_W), .FCNT_W(FCNT_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (conv_done),
    .res_sign   (res_sign),
    .res_data   (res_data),
    .fcnt       (fcnt_q),
    .frame_word (frame_word),
    .bit_out    (frame_bit)
  );

  assign sdo_oe = !cs_n;
  assign sdo    = cs_n ? 1'b0 :
                  (state_q == ST_DATA) ? frame_bit : (state_q == ST_CONV);
endmodule

// File: rtl/adc_sp_checker.sv
module adc_sp_checker
  import adc_sp_pkg::*;
#(
  parameter int FRAME_W = 19,
  parameter int FCNT_W  = 5,
  parameter int RCNT_W  = 4
) (
  input logic               clk,
  input logic               rst_sync_n,
  input logic               cs_n,
  input logic               sck_rise,
  input logic               sck_fall,
  input sp_state_e          state_q,
  input logic [FCNT_W-1:0]  fcnt_q,
  input logic [RCNT_W-1:0]  rcnt,
  input logic [CFG_W-1:0]   chan_cfg,
  input logic               mode_set_q,
  input logic               ext_clk_mode,
  input logic [FRAME_W-1:0] frame_word,
  input logic               sdo
);
  assert_last_fall_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DATA && !cs_n && sck_fall && fcnt_q == FCNT_W'(FRAME_W - 1))
    |=> (state_q == ST_CONV && (cs_n || sdo)));

  assert_abort_restart_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DATA && cs_n) |=> (state_q == ST_CONV));

  assert_addr_keep_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_DATA && cs_n && rcnt < RCNT_W'(ADDR_W)) |=> $stable(chan_cfg));

  assert_cfg_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(chan_cfg) |-> $past(sck_rise));

  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_SLEEP && $past(state_q) == ST_SLEEP) |-> $stable(frame_word));

  assert_mode_fixed_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mode_set_q |=> $stable(ext_clk_mode));
endmodule

bind adc_serial_port adc_sp_checker #(
  .FRAME_W(FRAME_W), .FCNT_W(FCNT_W), .RCNT_W(RCNT_W)
) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cs_n         (cs_n),
  .sck_rise     (sck_rise),
  .sck_fall     (sck_fall),
  .state_q      (state_q),
  .fcnt_q       (fcnt_q),
  .rcnt         (rcnt),
  .chan_cfg     (chan_cfg),
  .mode_set_q   (mode_set_q),
  .ext_clk_mode (ext_clk_mode),
  .frame_word   (frame_word),
  .sdo          (sdo)
);

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;
  localparam int CONV = 20;

  logic clk = 1'b0;
  logic rst_n, sck, cs_n, sdi, res_sign;
  logic [15:0] res_data;
  logic sdo, sdo_oe, ext_clk_mode;
  logic [5:0] chan_cfg;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  adc_serial_port #(.RES_W(16), .CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .res_data(res_data), .res_sign(res_sign), .sdo(sdo), .sdo_oe(sdo_oe),
    .ext_clk_mode(ext_clk_mode), .chan_cfg(chan_cfg)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] frame_of(input logic s, input logic [15:0] d);
    return {2'b00, s, d};
  endfunction

  task automatic run_frame(input logic [7:0] word, input logic [18:0] exp,
                           input int abort_at, input bit chk);
    for (int i = 0; i < 19; i++) begin
      if (i == abort_at) begin
        cs_n = 1'b1;
        wait_n(2);
        return;
      end
      sdi = (i < 8) ? word[7-i] : 1'b0;
      sck = 1'b1;
      wait_n(2);
      if (chk) check(32'(sdo), 32'(exp[18-i]), $sformatf("R4 bit %0d at rise", i));
      sck = 1'b0;
      wait_n(2);
      if (chk && i < 18) check(32'(sdo), 32'(exp[17-i]), $sformatf("R3 bit %0d after fall", i + 1));
    end
  endtask

  initial begin
    wait_n(150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [18:0] held;
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b1; sdi = 1'b0;
    res_data = 16'h5A3C; res_sign = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(5);
    check(32'(ext_clk_mode), 1, "R10 mode latched with sck low");
    check(32'(sdo_oe), 0, "R2 oe off with cs high");
    check(32'(sdo), 0, "R2 sdo quiet with cs high");
    check(32'(chan_cfg), 0, "R8 cfg reset value");
    cs_n = 1'b0;
    wait_n(1);
    check(32'(sdo_oe), 1, "R2 oe on with cs low");
    check(32'(sdo), 1, "R1 busy during conversion");
    wait_n(30);
    check(32'(sdo), 0, "R1 ready after conversion");

    for (int k = 0; k < 64; k++) begin
      d = 16'((k * 1031 + 16'h5A3C) & 16'hFFFF);
      run_frame({2'b10, 6'(k)}, frame_of(k[0], d), 99, 1'b1);
      d = 16'(((k + 1) * 1031 + 16'h5A3C) & 16'hFFFF);
      res_data = d; res_sign = ~k[0];
      check(32'(chan_cfg), 32'(k), "R8 cfg after full word");
      wait_n(16);
      check(32'(sdo), 1, "R5 busy through conversion");
      wait_n(4);
      check(32'(sdo), 0, "R5 conversion ends after CONV_CYCLES");
    end

    run_frame(8'b10_010101, 19'd0, 5, 1'b0);
    check(32'(chan_cfg), 63, "R7 early abort keeps cfg");
    cs_n = 1'b0;
    wait_n(1);
    check(32'(sdo), 1, "R6 abort starts conversion");
    wait_n(25);
    run_frame(8'b10_010101, 19'd0, 10, 1'b0);
    check(32'(chan_cfg), 32'h15, "R7 late abort keeps new cfg");
    cs_n = 1'b0;
    wait_n(25);
    run_frame(8'b11_000111, 19'd0, 99, 1'b0);
    check(32'(chan_cfg), 32'h15, "R8 bad lead word ignored");

    res_data = 16'hC3A1; res_sign = 1'b1;
    held = frame_of(1'b1, 16'hC3A1);
    cs_n = 1'b1;
    wait_n(25);
    res_data = 16'h1234; res_sign = 1'b0;
    wait_n(10);
    cs_n = 1'b0;
    wait_n(2);
    check(32'(sdo), 0, "R9 sleep before read");
    run_frame(8'b10_000001, held, 99, 1'b1);
    check(32'(chan_cfg), 1, "R9 cfg after held frame");

    cs_n = 1'b1;
    rst_n = 1'b0; sck = 1'b1;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(5);
    check(32'(ext_clk_mode), 0, "R10 mode latched with sck high");
    sck = 1'b0;
    cs_n = 1'b0;
    wait_n(30);
    for (int i = 0; i < 19; i++) begin
      sck = 1'b1; wait_n(2);
      sck = 1'b0; wait_n(2);
    end
    check(32'(sdo), 0, "R10 sck edges ignored");
    check(32'(chan_cfg), 0, "R10 no address capture");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule